// File: doc/BRIEF.md
# Downstream Non-Posted Ordering Gate with Attribute Translation

This block sits in the downstream request path of a bridge from a packet link to a PCI-X secondary bus. Every request from the link passes through it in arrival order. Non-posted requests carry a sequence tag. When the tag is nonzero, the block lets only one request with that tag be in flight on the secondary bus. A second request with the same tag waits at the head of the stream until the secondary side reports that the first one has completed. Tag zero means the request is not ordered, and the block never tracks it.

On the same path the block works out the two PCI-X attribute bits for each forwarded request. The relaxed-ordering bit comes from a different link bit for each request class. The no-snoop bit comes from the link coherent bit for memory traffic and is zero for all other traffic. The forwarding path is combinational. The per-tag state is a bitmap. A tag's bit is set when a tracked request is issued and cleared when the completion for that tag returns. The input is held back through its ready signal, so requests are never reordered.

Top module: `dn_order_gate`

## Requirements
- R1: After reset no tag is marked busy, so the first non-posted request with any nonzero tag is accepted in the same cycle it is presented, provided `fwd_ready` is high.
- R2: While a non-posted request with nonzero tag T is outstanding, a new non-posted request with tag T is held. It stays held until the completion for T arrives: `req_ready` and `fwd_valid` stay low. Both kind 01 (memory read) and kind 10 (non-memory non-posted) are held this way.
- R3: Accepting a non-posted request with a nonzero tag marks that tag busy from the next cycle on. Each tag is tracked on its own, so a busy tag never holds back a request with a different tag.
- R4: A completion for tag T clears its busy mark from the next cycle on. A completion for T that arrives in the same cycle as a held request with tag T releases that request in the same cycle.
- R5: Requests with tag 0 are never tracked and never held.
- R6: Kind 00 (posted memory write) and kind 11 (response to an upstream request) are never tracked and never held, whatever their tag.
- R7: No-snoop equals the inverse of `req_coh` for the memory kinds 00 and 01. It is 0 for kinds 10 and 11.
- R8: Relaxed-ordering equals `req_pass_pw` for kind 00 and `req_cmd3` (response may pass posted write) for kind 01. It is 0 for kind 10. For kind 11 it equals `req_orig_ro`, the attribute of the original upstream request.
- R9: While `fwd_ready` is low no request is accepted, and a request that is not accepted leaves its tag free.
- R10: When a completion for tag T and the issue of a new request with tag T fall in the same cycle, the completion is applied first and the issue second, so T stays busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Incoming request accepted this cycle |
| req_kind | input | 2 | 00 posted write, 01 memory read, 10 non-memory non-posted, 11 response |
| req_seq | input | 4 | Sequence tag (0 = not ordered) |
| req_cmd3 | input | 1 | Read command bit 3: response may pass posted write |
| req_coh | input | 1 | Link coherent bit |
| req_pass_pw | input | 1 | Link pass-posted-write bit |
| req_orig_ro | input | 1 | Relaxed-ordering attribute of the original upstream request (responses) |
| cpl_valid | input | 1 | Completion for a tracked tag returned from the secondary bus |
| cpl_seq | input | 4 | Tag of that completion |
| fwd_valid | output | 1 | Request offered to the secondary bus |
| fwd_ready | input | 1 | Secondary bus takes the offered request |
| fwd_kind | output | 2 | Kind of the forwarded request |
| fwd_seq | output | 4 | Tag of the forwarded request |
| fwd_ro | output | 1 | PCI-X relaxed-ordering attribute |
| fwd_ns | output | 1 | PCI-X no-snoop attribute |

## Verification
The completion path and the issue path can act on the same tag in the same cycle. The bench tests this in two ways. First, it holds a request behind a busy tag and drives the completion for that tag in a cycle while the request is still presented. The request must be released in that same cycle. Then it offers the same tag again, and that request must now be held, which shows that the clear came first and the set second. A monitor matches every forwarded request against a queue of expected kinds, tags and attributes, so any release out of order or any wrong attribute shows up as a mismatch.

// File: rtl/dn_gate_pkg.sv
package dn_gate_pkg;

  typedef enum logic [1:0] {
    KIND_PWR  = 2'b00,
    KIND_MRD  = 2'b01,
    KIND_NPIO = 2'b10,
    KIND_RSP  = 2'b11
  } dn_kind_e;

  function automatic logic kind_nonposted(input dn_kind_e k);
    return (k == KIND_MRD) || (k == KIND_NPIO);
  endfunction

  function automatic logic kind_memory(input dn_kind_e k);
    return (k == KIND_PWR) || (k == KIND_MRD);
  endfunction

endpackage

// File: rtl/dn_rst_sync.sv
module dn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_n_out = stage_q[STAGES-1];

endmodule

// File: rtl/dn_req_class.sv
module dn_req_class
  import dn_gate_pkg::*;
#(
  parameter int SEQ_W = 4
) (
  input  logic [1:0]       kind,
  input  logic [SEQ_W-1:0] seq,
  output logic             nonposted,
  output logic             memory,
  output logic             tracked
);

  dn_kind_e kind_e;

  always_comb begin
    kind_e    = dn_kind_e'(kind);
    nonposted = kind_nonposted(kind_e);
    memory    = kind_memory(kind_e);
    tracked   = nonposted && (seq != '0);
  end

endmodule

// File: rtl/dn_attr_map.sv
module dn_attr_map
  import dn_gate_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       memory,
  input  logic       cmd3,
  input  logic       coh,
  input  logic       pass_pw,
  input  logic       orig_ro,
  output logic       ro,
  output logic       ns
);

  always_comb begin
    unique case (dn_kind_e'(kind))
      KIND_PWR:  ro = pass_pw;
      KIND_MRD:  ro = cmd3;
      KIND_NPIO: ro = 1'b0;
      KIND_RSP:  ro = orig_ro;
      default:   ro = 1'b0;
    endcase
    ns = memory ? ~coh : 1'b0;
  end

endmodule

// File: rtl/dn_seq_tracker.sv
module dn_seq_tracker #(
  parameter int SEQ_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    set_en,
  input  logic [SEQ_W-1:0]        set_seq,
  input  logic                    clr_en,
  input  logic [SEQ_W-1:0]        clr_seq,
  input  logic [SEQ_W-1:0]        look_seq,
  output logic [(1<<SEQ_W)-1:0]   busy,
  output logic                    look_busy
);

  localparam int NSLOT = 1 << SEQ_W;

  assign busy[0] = 1'b0;

  for (genvar i = 1; i < NSLOT; i++) begin : g_slot
    logic hit_set;
    logic hit_clr;
    logic slot_en;
    logic slot_d;
    logic slot_q;

    always_comb begin
      hit_set = set_en && (set_seq == SEQ_W'(i));
      hit_clr = clr_en && (clr_seq == SEQ_W'(i));
      slot_en = hit_set || hit_clr;
      slot_d  = hit_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= 1'b0;
      end else if (slot_en) begin
        slot_q <= slot_d;
      end
    end

    assign busy[i] = slot_q;
  end

  always_comb begin
    look_busy = busy[look_seq] && !(clr_en && (clr_seq == look_seq));
  end

endmodule

// File: rtl/dn_order_gate.sv
module dn_order_gate #(
  parameter int SEQ_W      = 4,
  parameter int SYNC_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic             req_cmd3,
  input  logic             req_coh,
  input  logic             req_pass_pw,
  input  logic             req_orig_ro,
  input  logic             cpl_valid,
  input  logic [SEQ_W-1:0] cpl_seq,
  output logic             fwd_valid,
  input  logic             fwd_ready,
  output logic [1:0]       fwd_kind,
  output logic [SEQ_W-1:0] fwd_seq,
  output logic             fwd_ro,
  output logic             fwd_ns
);

  localparam int NSLOT = 1 << SEQ_W;

  logic             rst_sync_n;
  logic             is_np;
  logic             is_mem;
  logic             is_tracked;
  logic             conflict;
  logic             issue;
  logic             set_en;
  logic             clr_en;
  logic [NSLOT-1:0] seq_busy;

  dn_rst_sync #(.STAGES(SYNC_STAGE)) i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  dn_req_class #(.SEQ_W(SEQ_W)) i_class (
    .kind      (req_kind),
    .seq       (req_seq),
    .nonposted (is_np),
    .memory    (is_mem),
    .tracked   (is_tracked)
  );

  dn_attr_map i_attr (
    .kind    (req_kind),
    .memory  (is_mem),
    .cmd3    (req_cmd3),
    .coh     (req_coh),
    .pass_pw (req_pass_pw),
    .orig_ro (req_orig_ro),
    .ro      (fwd_ro),
    .ns      (fwd_ns)
  );

  dn_seq_tracker #(.SEQ_W(SEQ_W)) i_tracker (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_en    (set_en),
    .set_seq   (req_seq),
    .clr_en    (clr_en),
    .clr_seq   (cpl_seq),
    .look_seq  (req_seq),
    .busy      (seq_busy),
    .look_busy (conflict)
  );

  always_comb begin
    fwd_valid = rst_sync_n && req_valid && !(is_tracked && conflict);
    req_ready = rst_sync_n && fwd_ready && !(is_tracked && conflict);
    issue     = req_valid && req_ready;
    set_en    = issue && is_tracked;
    clr_en    = rst_sync_n && cpl_valid && (cpl_seq != '0);
    fwd_kind  = req_kind;
    fwd_seq   = req_seq;
  end

  logic unused_np;
  assign unused_np = is_np;

endmodule

// File: rtl/dn_order_gate_chk.sv
module dn_order_gate_chk #(
  parameter int SEQ_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [1:0]            req_kind,
  input logic [SEQ_W-1:0]      req_seq,
  input logic                  cpl_valid,
  input logic [SEQ_W-1:0]      cpl_seq,
  input logic                  fwd_valid,
  input logic                  fwd_ready,
  input logic                  fwd_ro,
  input logic                  fwd_ns,
  input logic [(1<<SEQ_W)-1:0] seq_busy
);

  logic np_req;
  logic tr_issue;

  always_comb begin
    np_req   = (req_kind == 2'b01) || (req_kind == 2'b10);
    tr_issue = req_valid && req_ready && np_req && (req_seq != '0);
  end

  p_no_dup_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tr_issue |-> (!seq_busy[req_seq] || (cpl_valid && cpl_seq == req_seq)));

  p_set_on_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tr_issue |=> seq_busy[$past(req_seq)]);

  p_clear_on_cpl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_seq != '0 && !(tr_issue && req_seq == cpl_seq))
      |=> !seq_busy[$past(cpl_seq)]);

  p_seq0_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_seq == '0 && fwd_ready) |-> req_ready);

  p_posted_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !np_req && fwd_ready) |-> req_ready);

  p_ns_nonmem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && req_kind[1]) |-> !fwd_ns);

  p_ro_npio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && req_kind == 2'b10) |-> !fwd_ro);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !fwd_ready) |-> !req_ready);

  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_issue && cpl_valid && cpl_seq == req_seq) |=> seq_busy[$past(req_seq)]);

endmodule

bind dn_order_gate dn_order_gate_chk #(.SEQ_W(SEQ_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .req_seq   (req_seq),
  .cpl_valid (cpl_valid),
  .cpl_seq   (cpl_seq),
  .fwd_valid (fwd_valid),
  .fwd_ready (fwd_ready),
  .fwd_ro    (fwd_ro),
  .fwd_ns    (fwd_ns),
  .seq_busy  (seq_busy)
);

// File: tb/test_dn_order_gate.sv
module test_dn_order_gate;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [1:0] req_kind;
  logic [3:0] req_seq;
  logic       req_cmd3;
  logic       req_coh;
  logic       req_pass_pw;
  logic       req_orig_ro;
  logic       cpl_valid;
  logic [3:0] cpl_seq;
  logic       fwd_valid;
  logic       fwd_ready;
  logic [1:0] fwd_kind;
  logic [3:0] fwd_seq;
  logic       fwd_ro;
  logic       fwd_ns;

  int n_chk;
  int n_fail;
  logic [7:0] exp_q[$];

  dn_order_gate i_dn_order_gate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_seq(req_seq), .req_cmd3(req_cmd3), .req_coh(req_coh),
    .req_pass_pw(req_pass_pw), .req_orig_ro(req_orig_ro),
    .cpl_valid(cpl_valid), .cpl_seq(cpl_seq),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_kind(fwd_kind),
    .fwd_seq(fwd_seq), .fwd_ro(fwd_ro), .fwd_ns(fwd_ns)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_ro(input logic [1:0] k, input logic c3, input logic pw,
                                  input logic oro);
    case (k)
      2'b00:   return pw;
      2'b01:   return c3;
      2'b10:   return 1'b0;
      default: return oro;
    endcase
  endfunction

  function automatic logic exp_ns(input logic [1:0] k, input logic coh);
    return k[1] ? 1'b0 : ~coh;
  endfunction

  // R7 R8: scoreboard monitor compares each forwarded request
  always @(negedge clk) begin
    if (rst_n && fwd_valid && fwd_ready) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected forward", {fwd_kind, fwd_seq, fwd_ro, fwd_ns}, 8'hxx);
      end else begin
        check("R7/R8 forwarded item", {fwd_kind, fwd_seq, fwd_ro, fwd_ns}, exp_q.pop_front());
      end
    end
  end

  task automatic present(input logic [1:0] k, input logic [3:0] s, input logic c3,
                         input logic coh, input logic pw, input logic oro, input bit push);
    req_kind = k; req_seq = s; req_cmd3 = c3; req_coh = coh;
    req_pass_pw = pw; req_orig_ro = oro; req_valid = 1'b1;
    if (push) exp_q.push_back({k, s, exp_ro(k, c3, pw, oro), exp_ns(k, coh)});
  endtask

  task automatic send(input logic [1:0] k, input logic [3:0] s, input logic c3,
                      input logic coh, input logic pw, input logic oro, input string imm);
    present(k, s, c3, coh, pw, oro, 1'b1);
    @(negedge clk);
    if (imm != "") check(imm, {7'd0, req_ready}, 8'd1);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic probe_held(input logic [1:0] k, input logic [3:0] s, input string tag);
    present(k, s, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(tag, {7'd0, req_ready}, 8'd0);
    check(tag, {7'd0, fwd_valid}, 8'd0);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic complete(input logic [3:0] s);
    cpl_valid = 1'b1; cpl_seq = s;
    @(posedge clk); #1;
    cpl_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_seq = '0;
    req_cmd3 = 1'b0; req_coh = 1'b0; req_pass_pw = 1'b0; req_orig_ro = 1'b0;
    cpl_valid = 1'b0; cpl_seq = '0; fwd_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    check("R1 idle fwd_valid", {7'd0, fwd_valid}, 8'd0);
    @(posedge clk); #1;

    // R1: first tagged read passes at once; R8 cmd3 -> ro, R7 coh -> ns
    send(2'b01, 4'd7, 1'b1, 1'b1, 1'b0, 1'b0, "R1 first tag 7");

    // R2: same tag held, then R4 same-cycle release by completion
    present(2'b01, 4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 held ready", {7'd0, req_ready}, 8'd0);
      check("R2 held fwd_valid", {7'd0, fwd_valid}, 8'd0);
    end
    @(posedge clk); #1;
    cpl_valid = 1'b1; cpl_seq = 4'd7;
    @(negedge clk);
    check("R4 bypass release", {7'd0, req_ready}, 8'd1);
    @(posedge clk); #1;
    cpl_valid = 1'b0; req_valid = 1'b0;

    // R10: clear-then-set leaves tag 7 busy
    probe_held(2'b01, 4'd7, "R10 tag stays busy");
    complete(4'd7);
    send(2'b01, 4'd7, 1'b0, 1'b1, 1'b1, 1'b1, "R4 freed after completion");

    // R5: tag 0 never tracked
    send(2'b01, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 tag0 first");
    send(2'b01, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 tag0 second");
    send(2'b10, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, "R5 tag0 nonmem");

    // R6 with R7/R8: posted kinds pass a busy tag 7
    send(2'b00, 4'd7, 1'b0, 1'b0, 1'b1, 1'b0, "R6 posted write passes");
    send(2'b00, 4'd7, 1'b1, 1'b1, 1'b0, 1'b1, "R6 posted write 2");
    send(2'b11, 4'd7, 1'b0, 1'b0, 1'b0, 1'b1, "R6 response passes");
    send(2'b11, 4'd7, 1'b1, 1'b0, 1'b1, 1'b0, "R6 response 2");

    // R8/R7 non-memory non-posted, and R2 hold for that kind
    send(2'b10, 4'd9, 1'b1, 1'b0, 1'b1, 1'b1, "R8 nonmem tag 9");
    probe_held(2'b10, 4'd9, "R2 nonmem held");
    complete(4'd9);

    // R9: no acceptance without fwd_ready, tag left free
    fwd_ready = 1'b0;
    present(2'b01, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 not accepted", {7'd0, req_ready}, 8'd0);
    @(posedge clk); #1;
    req_valid = 1'b0; fwd_ready = 1'b1;
    send(2'b01, 4'd5, 1'b1, 1'b1, 1'b0, 1'b0, "R9 tag still free");
    complete(4'd5);
    complete(4'd7);

    // R3: every tag independent, set on issue
    for (int s = 1; s < 16; s++) send(2'b01, 4'(s), s[0], s[1], 1'b0, 1'b0, "R3 each tag free");
    for (int s = 1; s < 16; s++) probe_held(2'b01, 4'(s), "R3 each tag busy");
    for (int s = 1; s < 16; s++) complete(4'(s));
    for (int s = 1; s < 16; s++) send(2'b10, 4'(s), 1'b0, 1'b0, 1'b0, 1'b0, "R4 each tag freed");
    for (int s = 1; s < 16; s++) complete(4'(s));

    repeat (2) @(posedge clk);
    check("R2 scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule